// File: doc/BRIEF.md
# Paged Address Translator with Recency-Ordered TLB and Frame Pool

This block turns a stream of 8-bit byte addresses into 7-bit physical addresses for a small paged memory. The virtual space is split into sixteen 16-byte pages. Physical memory holds eight 16-byte frames, and the top frame (frame 7) permanently holds the single-level page table. A three-entry, fully associative translation buffer caches recent page-to-frame mappings in front of that table.

Each accepted reference takes one of three paths. A buffer hit answers at once. A buffer miss walks the page table. A reference to a non-resident page is a fault. On a fault, the block places the page in the lowest-numbered empty frame, or evicts the least recently used resident page. It then updates the page table and refills the buffer. Both the buffer and the frame pool keep their own recency order, and every reference refreshes both orders, hits included.

The control is a six-state machine:
- IDLE waits for a request and goes to LOOKUP when one is accepted.
- LOOKUP probes the buffer. It goes to RESPOND on a hit and to WALK on a miss.
- WALK reads the table entry. It goes to FILL if the page is present and to FAULT if it is not.
- FAULT allocates a frame, performing any eviction, and goes to FILL.
- FILL writes the buffer entry and goes to RESPOND.
- RESPOND raises the result strobe for one cycle and returns to IDLE.

Top module: `page_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. The buffer maps page 0 to frame 5, page 2 to frame 3 and page 13 to frame 1. In the buffer's recency order, page 13 is newest and page 0 is oldest. In memory, frame 1 holds page 13, frame 2 page 5, frame 3 page 2 and frame 5 page 0, and frames 0, 4 and 6 are empty. The frame recency order, newest first, is 3, 2, 1, 5, 0, 4, 6.
- R2: A reference whose page is in the buffer gives a strobe with rsp_tlb_hit=1, rsp_fault=0 and the mapped frame, 2 cycles after acceptance.
- R3: A buffer miss on a resident page gives rsp_tlb_hit=0, rsp_fault=0 and the frame from the page table, 4 cycles after acceptance.
- R4: A reference to a non-resident page gives rsp_tlb_hit=0, rsp_fault=1 and the newly assigned frame, 5 cycles after acceptance.
- R5: rsp_paddr equals {rsp_frame, low 4 bits of the request address}. The page number is req_vaddr[7:4].
- R6: A fault with at least one empty frame among frames 0 to 6 uses the lowest-numbered empty frame.
- R7: A fault with no empty frame evicts the least recently used of frames 0 to 6. Frame 7 is never reported or used.
- R8: An evicted page is marked not present and its buffer entry, if any, is invalidated, so a later reference to it faults.
- R9: A buffer refill takes the lowest-numbered invalid entry, or else the least recently used entry.
- R10: Every reference, hit or not, makes its buffer entry and its frame the most recent in their orders.
- R11: req_valid is ignored while req_ready is 0.
- R12: rsp_valid is high for exactly one cycle per accepted reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Reference request, taken when req_ready is 1 |
| req_vaddr | input | 8 | Virtual byte address: page in [7:4], offset in [3:0] |
| req_ready | output | 1 | Block is idle and will accept a request |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_tlb_hit | output | 1 | Reference hit in the translation buffer |
| rsp_fault | output | 1 | Reference caused a page fault |
| rsp_frame | output | 3 | Frame number used by the reference |
| rsp_paddr | output | 7 | Physical byte address |

## Verification
The result arrives a fixed number of cycles after the accepting edge, and that number depends only on the path: 2 cycles for a hit, 4 for a resident miss and 5 for a fault. For every reference, the bench counts clock edges from acceptance to the strobe and compares the count with the path implied by the expected hit and fault flags. It samples the strobe and result fields at the falling edge, half a cycle after the registers settle. One directed case holds a second request on the input throughout the busy window and then watches for any extra strobe.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VPN_W      = 4;
    localparam int OFF_W      = 4;
    localparam int VA_W       = VPN_W + OFF_W;
    localparam int FRAME_W    = 3;
    localparam int NUM_FRAMES = 1 << FRAME_W;
    localparam int NUM_PAGES  = 1 << VPN_W;
    localparam int PA_W       = FRAME_W + OFF_W;
    localparam logic [FRAME_W-1:0] PT_FRAME = FRAME_W'(NUM_FRAMES - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK,
        ST_FAULT,
        ST_FILL,
        ST_RESPOND
    } xlat_state_e;

    typedef struct packed {
        logic               valid;
        logic [VPN_W-1:0]   vpn;
        logic [FRAME_W-1:0] frame;
    } tlb_entry_t;
endpackage

// File: rtl/xlat_lru_order.sv
module xlat_lru_order #(
    parameter int N = 3,
    parameter logic [N*$clog2(N)-1:0] RESET_AGES = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 touch,
    input  logic [$clog2(N)-1:0] touch_idx,
    output logic [$clog2(N)-1:0] oldest_idx
);
    localparam int AW = $clog2(N);
    localparam logic [AW-1:0] MAX_AGE = AW'(N - 1);

    logic [AW-1:0] age_q [N];
    logic          oldest_found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                age_q[i] <= RESET_AGES[i*AW +: AW];
            end
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (touch_idx == AW'(i)) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        oldest_idx   = '0;
        oldest_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == MAX_AGE) begin
                oldest_idx   = AW'(i);
                oldest_found = 1'b1;
            end
        end
    end

    // R10: the ages stay a permutation, so an oldest slot always exists
    assert_oldest_exists_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oldest_found);
    // R10: a touched slot becomes the newest
    assert_touch_newest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 3,
    parameter logic [ENTRIES*VPN_W-1:0]          RESET_VPNS   = '0,
    parameter logic [ENTRIES*FRAME_W-1:0]        RESET_FRAMES = '0,
    parameter logic [ENTRIES*$clog2(ENTRIES)-1:0] RESET_AGES  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lookup_vpn,
    output logic               hit,
    output logic [FRAME_W-1:0] hit_frame,
    input  logic               hit_touch,
    input  logic               wr_en,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               inval_en,
    input  logic [VPN_W-1:0]   inval_vpn
);
    localparam int IW = $clog2(ENTRIES);

    tlb_entry_t         ent_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IW-1:0]      hit_idx;
    logic [IW-1:0]      free_idx;
    logic               any_free;
    logic [IW-1:0]      oldest_idx;
    logic [IW-1:0]      wr_idx;
    logic               lru_touch;
    logic [IW-1:0]      lru_idx;

    always_comb begin
        hit_idx   = '0;
        hit_frame = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            match[i] = ent_q[i].valid && (ent_q[i].vpn == lookup_vpn);
            if (match[i]) begin
                hit_idx   = IW'(i);
                hit_frame = ent_q[i].frame;
            end
        end
        hit = |match;
    end

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_q[i].valid) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
        end
        wr_idx    = any_free ? free_idx : oldest_idx;
        lru_touch = wr_en || hit_touch;
        lru_idx   = wr_en ? wr_idx : hit_idx;
    end

    xlat_lru_order #(
        .N          (ENTRIES),
        .RESET_AGES (RESET_AGES)
    ) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (lru_touch),
        .touch_idx  (lru_idx),
        .oldest_idx (oldest_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '{valid: 1'b1,
                              vpn:   RESET_VPNS[i*VPN_W +: VPN_W],
                              frame: RESET_FRAMES[i*FRAME_W +: FRAME_W]};
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && wr_idx == IW'(i)) begin
                    ent_q[i] <= '{valid: 1'b1, vpn: wr_vpn, frame: wr_frame};
                end else if (inval_en && ent_q[i].valid && ent_q[i].vpn == inval_vpn) begin
                    ent_q[i].valid <= 1'b0;
                end
            end
        end
    end

    // R9: a page never occupies two entries
    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);
    // R8: an invalidated page no longer hits
    assert_inval_gone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_en && !wr_en) |=> !(ent_q[0].valid && ent_q[0].vpn == $past(inval_vpn)));
    // R9: a refill is visible as a hit on the next cycle
    assert_refill_hits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lookup_vpn == wr_vpn) |=> (hit && hit_frame == $past(wr_frame)));
endmodule

// File: rtl/xlat_frames.sv
module xlat_frames
    import xlat_pkg::*;
#(
    parameter int USER_FRAMES = NUM_FRAMES - 1,
    parameter logic [USER_FRAMES-1:0]             RESET_OWNED = '0,
    parameter logic [USER_FRAMES*VPN_W-1:0]       RESET_OWNER = '0,
    parameter logic [USER_FRAMES*FRAME_W-1:0]     RESET_AGES  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   walk_vpn,
    output logic               pte_present,
    output logic [FRAME_W-1:0] pte_frame,
    input  logic               alloc_en,
    output logic [FRAME_W-1:0] alloc_frame,
    output logic               evict_valid,
    output logic [VPN_W-1:0]   evict_vpn,
    input  logic               touch_en,
    input  logic [FRAME_W-1:0] touch_frame
);
    logic                   pt_present [NUM_PAGES];
    logic [FRAME_W-1:0]     pt_frame   [NUM_PAGES];
    logic [USER_FRAMES-1:0] owned_q;
    logic [VPN_W-1:0]       owner_q    [USER_FRAMES];
    logic [FRAME_W-1:0]     free_frame;
    logic                   any_free;
    logic [FRAME_W-1:0]     oldest_frame;

    assign pte_present = pt_present[walk_vpn];
    assign pte_frame   = pt_frame[walk_vpn];

    always_comb begin
        free_frame = '0;
        any_free   = 1'b0;
        for (int i = USER_FRAMES - 1; i >= 0; i--) begin
            if (!owned_q[i]) begin
                free_frame = FRAME_W'(i);
                any_free   = 1'b1;
            end
        end
        alloc_frame = any_free ? free_frame : oldest_frame;
        evict_valid = owned_q[alloc_frame];
        evict_vpn   = owner_q[alloc_frame];
    end

    xlat_lru_order #(
        .N          (USER_FRAMES),
        .RESET_AGES (RESET_AGES)
    ) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch_en),
        .touch_idx  (touch_frame),
        .oldest_idx (oldest_frame)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                pt_present[p] <= 1'b0;
                pt_frame[p]   <= '0;
            end
            for (int f = 0; f < USER_FRAMES; f++) begin
                owned_q[f] <= RESET_OWNED[f];
                owner_q[f] <= RESET_OWNER[f*VPN_W +: VPN_W];
                if (RESET_OWNED[f]) begin
                    pt_present[RESET_OWNER[f*VPN_W +: VPN_W]] <= 1'b1;
                    pt_frame[RESET_OWNER[f*VPN_W +: VPN_W]]   <= FRAME_W'(f);
                end
            end
        end else if (alloc_en) begin
            if (evict_valid) begin
                pt_present[evict_vpn] <= 1'b0;
            end
            pt_present[walk_vpn]   <= 1'b1;
            pt_frame[walk_vpn]     <= alloc_frame;
            owned_q[alloc_frame]   <= 1'b1;
            owner_q[alloc_frame]   <= walk_vpn;
        end
    end

    // R4: the faulting page is present once allocated
    assert_alloc_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> pt_present[$past(walk_vpn)]);
    // R8: the evicted page leaves the table
    assert_evict_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && evict_valid) |=> !pt_present[$past(evict_vpn)]);
    // R6: allocation never evicts while an empty frame exists
    assert_empty_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !(&owned_q)) |-> !evict_valid);
endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import xlat_pkg::*;
#(
    parameter int TLB_ENTRIES = 3,
    parameter logic [TLB_ENTRIES*VPN_W-1:0]   TLB_RESET_VPNS   = {4'd13, 4'd2, 4'd0},
    parameter logic [TLB_ENTRIES*FRAME_W-1:0] TLB_RESET_FRAMES = {3'd1, 3'd3, 3'd5},
    parameter logic [TLB_ENTRIES*$clog2(TLB_ENTRIES)-1:0] TLB_RESET_AGES = {2'd0, 2'd1, 2'd2},
    parameter logic [NUM_FRAMES-2:0]           MEM_RESET_OWNED = 7'b0101110,
    parameter logic [(NUM_FRAMES-1)*VPN_W-1:0] MEM_RESET_OWNER =
        {4'd0, 4'd0, 4'd0, 4'd2, 4'd5, 4'd13, 4'd0},
    parameter logic [(NUM_FRAMES-1)*FRAME_W-1:0] MEM_RESET_AGES =
        {3'd6, 3'd3, 3'd5, 3'd0, 3'd1, 3'd2, 3'd4}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic               rsp_tlb_hit,
    output logic               rsp_fault,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic [PA_W-1:0]    rsp_paddr
);
    xlat_state_e        state_q, state_d;
    logic [VPN_W-1:0]   vpn_q;
    logic [OFF_W-1:0]   off_q;
    logic               hit_q, fault_q;
    logic [FRAME_W-1:0] frame_q;

    logic               tlb_hit;
    logic [FRAME_W-1:0] tlb_frame;
    logic               pte_present;
    logic [FRAME_W-1:0] pte_frame;
    logic [FRAME_W-1:0] alloc_frame;
    logic               evict_valid;
    logic [VPN_W-1:0]   evict_vpn;
    logic               in_lookup, in_fault, in_fill;
    logic               frame_touch;
    logic [FRAME_W-1:0] frame_touch_idx;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = tlb_hit ? ST_RESPOND : ST_WALK;
            ST_WALK:    state_d = pte_present ? ST_FILL : ST_FAULT;
            ST_FAULT:   state_d = ST_FILL;
            ST_FILL:    state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-reference result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            off_q   <= '0;
            hit_q   <= 1'b0;
            fault_q <= 1'b0;
            frame_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vpn_q   <= req_vaddr[VA_W-1 -: VPN_W];
                    off_q   <= req_vaddr[OFF_W-1:0];
                    hit_q   <= 1'b0;
                    fault_q <= 1'b0;
                end
                ST_LOOKUP: if (tlb_hit) begin
                    hit_q   <= 1'b1;
                    frame_q <= tlb_frame;
                end
                ST_WALK: if (pte_present) frame_q <= pte_frame;
                ST_FAULT: begin
                    fault_q <= 1'b1;
                    frame_q <= alloc_frame;
                end
                default: ;
            endcase
        end
    end

    assign in_lookup       = (state_q == ST_LOOKUP);
    assign in_fault        = (state_q == ST_FAULT);
    assign in_fill         = (state_q == ST_FILL);
    assign frame_touch     = (in_lookup && tlb_hit) || in_fill;
    assign frame_touch_idx = in_lookup ? tlb_frame : frame_q;

    xlat_tlb #(
        .ENTRIES      (TLB_ENTRIES),
        .RESET_VPNS   (TLB_RESET_VPNS),
        .RESET_FRAMES (TLB_RESET_FRAMES),
        .RESET_AGES   (TLB_RESET_AGES)
    ) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_vpn (vpn_q),
        .hit        (tlb_hit),
        .hit_frame  (tlb_frame),
        .hit_touch  (in_lookup && tlb_hit),
        .wr_en      (in_fill),
        .wr_vpn     (vpn_q),
        .wr_frame   (frame_q),
        .inval_en   (in_fault && evict_valid),
        .inval_vpn  (evict_vpn)
    );

    xlat_frames #(
        .USER_FRAMES (NUM_FRAMES - 1),
        .RESET_OWNED (MEM_RESET_OWNED),
        .RESET_OWNER (MEM_RESET_OWNER),
        .RESET_AGES  (MEM_RESET_AGES)
    ) u_frames (
        .clk         (clk),
        .rst_n       (rst_n),
        .walk_vpn    (vpn_q),
        .pte_present (pte_present),
        .pte_frame   (pte_frame),
        .alloc_en    (in_fault),
        .alloc_frame (alloc_frame),
        .evict_valid (evict_valid),
        .evict_vpn   (evict_vpn),
        .touch_en    (frame_touch),
        .touch_frame (frame_touch_idx)
    );

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        rsp_tlb_hit = hit_q;
        rsp_fault   = fault_q;
        rsp_frame   = frame_q;
        rsp_paddr   = {frame_q, off_q};
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_RESPOND: rsp_valid = 1'b1;
            default:    ;
        endcase
    end

    assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_hit_not_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_tlb_hit && rsp_fault));
    assert_no_table_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_frame != PT_FRAME);
    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);
    assert_fault_walked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |-> $past(state_q) == ST_WALK);
endmodule

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vaddr = '0;
    logic       req_ready, rsp_valid, rsp_tlb_hit, rsp_fault;
    logic [2:0] rsp_frame;
    logic [6:0] rsp_paddr;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    page_xlate u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_tlb_hit (rsp_tlb_hit),
        .rsp_fault   (rsp_fault),
        .rsp_frame   (rsp_frame),
        .rsp_paddr   (rsp_paddr)
    );

    typedef struct packed {
        logic [3:0] vpn;
        logic [3:0] off;
        logic       hit;
        logic       fault;
        logic [2:0] frame;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  4'd1,  1'b1, 1'b0, 3'd5}, // R2 preload hit
        '{4'd13, 4'd2,  1'b1, 1'b0, 3'd1}, // R2
        '{4'd5,  4'd3,  1'b0, 1'b0, 3'd2}, // R3, R9 replaces page 2
        '{4'd2,  4'd4,  1'b0, 1'b0, 3'd3}, // R3 / R9
        '{4'd14, 4'd5,  1'b0, 1'b1, 3'd0}, // R4 / R6 lowest empty
        '{4'd14, 4'd6,  1'b1, 1'b0, 3'd0}, // R2
        '{4'd13, 4'd7,  1'b0, 1'b0, 3'd1}, // R3
        '{4'd6,  4'd8,  1'b0, 1'b1, 3'd4}, // R6
        '{4'd6,  4'd9,  1'b1, 1'b0, 3'd4}, // R2
        '{4'd13, 4'd10, 1'b1, 1'b0, 3'd1}, // R10 hit refreshes order
        '{4'd15, 4'd11, 1'b0, 1'b1, 3'd6}, // R6 last empty frame
        '{4'd14, 4'd12, 1'b0, 1'b0, 3'd0}, // R3
        '{4'd15, 4'd13, 1'b1, 1'b0, 3'd6}, // R2
        '{4'd13, 4'd14, 1'b1, 1'b0, 3'd1}, // R2
        '{4'd4,  4'd15, 1'b0, 1'b1, 3'd5}, // R7 evicts page 0
        '{4'd3,  4'd0,  1'b0, 1'b1, 3'd2}, // R7 evicts page 5
        '{4'd0,  4'd1,  1'b0, 1'b1, 3'd3}, // R8 evicted page faults
        '{4'd5,  4'd2,  1'b0, 1'b1, 3'd4}, // R8
        '{4'd2,  4'd3,  1'b0, 1'b1, 3'd0}, // R8 / R7
        '{4'd14, 4'd4,  1'b0, 1'b1, 3'd6}, // R8 / R7
        '{4'd13, 4'd5,  1'b0, 1'b0, 3'd1}  // R3 / R10
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // apply one reference and check the strobe at the falling edge
    task automatic do_ref(input logic [3:0] vpn, input logic [3:0] off,
                          input bit ehit, input bit efault, input logic [2:0] eframe);
        int lat;
        int exp_lat;
        string tag;
        exp_lat = ehit ? 2 : (efault ? 5 : 4);
        tag = ehit ? "R2" : (efault ? "R4" : "R3");
        req_vaddr = {vpn, off};
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 20) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        check(rsp_valid && rsp_tlb_hit == ehit, {tag, " hit flag"}, rsp_tlb_hit, ehit);
        check(rsp_fault == efault, {tag, " fault flag"}, rsp_fault, efault);
        check(rsp_frame == eframe, {tag, "/R6/R7 frame"}, rsp_frame, eframe);
        check(rsp_paddr == {eframe, off}, "R5 paddr", rsp_paddr, {eframe, off});
        @(posedge clk);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R12 strobe one cycle", rsp_valid, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int strobes;
        do_reset();
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 no strobe after reset", rsp_valid, 0);

        for (int i = 0; i < NV; i++) begin
            do_ref(VECS[i].vpn, VECS[i].off, VECS[i].hit, VECS[i].fault, VECS[i].frame);
        end

        // R11: a request held on the input while busy is not taken
        req_vaddr = {4'd13, 4'd1};
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_vaddr = {4'd7, 4'd0};
        check(!req_ready, "R11 busy after accept", req_ready, 0);
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid && rsp_tlb_hit && rsp_frame == 3'd1, "R11 first reference result",
              rsp_frame, 1);
        req_valid = 1'b0;
        strobes = 0;
        for (int c = 0; c < 10; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (rsp_valid) strobes++;
        end
        check(strobes == 0, "R11 ignored request made no strobe", strobes, 0);
        check(req_ready, "R11 idle again", req_ready, 1);

        // R1: reset restores preloaded buffer and frame contents
        do_reset();
        check(req_ready && !rsp_valid, "R1 reset outputs", rsp_valid, 0);
        do_ref(4'd0, 4'd9, 1'b1, 1'b0, 3'd5);   // R1 buffer preload
        do_ref(4'd5, 4'd8, 1'b0, 1'b0, 3'd2);   // R1 frame preload
        do_ref(4'd4, 4'd7, 1'b0, 1'b1, 3'd0);   // R1 / R6 empty frame 0

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule